// File: doc/BRIEF.md
# Receive Frame Buffer with In-Band Status

This block is a 2 KB single-clock buffer between a MAC receive path and a downstream reader. The write side delivers a frame as a series of 32-bit words. The final word is flagged, together with a count of its valid bytes. A 32-bit status word for that frame follows. The status word goes into the same memory, directly behind the frame's final data word. As a result, any number of complete frames can wait in the buffer with no second queue for their status. Each of the 512 words carries a tag: plain data, final data, or status.

The reader is allowed into a frame under one of two rules, chosen by a mode bit. In store-and-forward mode, a frame opens only after its status word has been written. In cut-through mode, a frame also opens once the bytes stored for the frame being written reach a programmable threshold. That threshold resets to 64 bytes.

If a frame runs out of room, what happens depends on the reader. If the reader has not yet entered that frame, the write pointer rewinds to the frame's first word and the frame vanishes. If the reader has already entered it, the rest of the frame's data is thrown away and its status is stored with its top bit forced to 1. Both cases increment a drop counter. One word is always held in reserve, so the status word always has room.

Writer states: `W_IDLE`, `W_FRAME`, `W_WAIT_STS`, `W_DISCARD`.
- `W_IDLE`/`W_FRAME` go to `W_FRAME` on a data word, or to `W_WAIT_STS` on the final word.
- `W_IDLE`/`W_FRAME` go to `W_DISCARD` on a data word that finds no room.
- `W_WAIT_STS` goes to `W_IDLE` when the status word is stored.
- `W_DISCARD` goes to `W_IDLE` when the status word arrives.

Reader states: `R_IDLE` and `R_FRAME`.
- `R_IDLE` goes to `R_FRAME` when a complete frame is queued, or, in cut-through mode, when the threshold is met.
- `R_FRAME` goes to `R_IDLE` when it pops a status word.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the buffer reports `empty`=1, `full`=0, `level`=0, `rd_avail`=0, `drop_count`=0, cut-through mode, and a 64-byte threshold.
- R2: In store-and-forward mode (`cfg_store_fwd`=1), `rd_avail` stays 0 until the frame's status word is stored. It rises one clock after that write.
- R2 (continued): The frame is read back in write order. Data words come out with `rd_valid`=1. The final data word also has `rd_last`=1. The status word comes last, with `rd_sts_valid`=1 and `rd_valid`=0.
- R3: In cut-through mode with the default threshold, `rd_avail` stays 0 while 15 words (60 bytes) of the current frame are stored. It rises one clock after the 16th word is written.
- R4: A write with `cfg_we`=1 loads `cfg_thresh` (in bytes) and `cfg_store_fwd`. The new threshold governs when the reader may enter a frame.
- R5: In cut-through mode, a frame shorter than the threshold becomes readable one clock after its status word is stored.
- R6: Several complete frames can be queued, each followed by its status word. They are read back in order, and each read ends with its own status.
- R7: `level` counts stored words, status words included. The buffer holds 512 words. `full`=1 exactly at 512 words, and `empty`=1 exactly at 0 words.
- R8: A data word that arrives when 511 words are stored overflows the frame. If the reader has not entered that frame, the frame is removed: `level` returns to its value before the frame and `drop_count` increments. The next frame is stored intact.
- R9: If the reader has already entered the overflowing frame, its remaining data words are dropped. Its status word is stored with bit 31 set, and `drop_count` increments.
- R10: `rd_en` has no effect while `rd_avail`=0: no word is output and none is consumed.
- R11: `wr_bytes` on the final word gives its valid bytes (0 means 4, 1 to 3 mean that many). The value comes back on `rd_bytes` together with `rd_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load threshold and mode |
| cfg_thresh | input | 12 | Cut-through threshold in bytes |
| cfg_store_fwd | input | 1 | 1 = store-and-forward mode |
| wr_valid | input | 1 | Frame data word present |
| wr_data | input | 32 | Frame data word |
| wr_last | input | 1 | Word is the frame's final data word |
| wr_bytes | input | 2 | Valid bytes in final word (0 = 4) |
| sts_valid | input | 1 | Status word present |
| sts_data | input | 32 | Frame status word |
| rd_en | input | 1 | Pop one word when `rd_avail` is 1 |
| rd_avail | output | 1 | Reader is in a frame and a word is stored |
| rd_valid | output | 1 | `rd_data` holds a data word |
| rd_data | output | 32 | Popped word |
| rd_last | output | 1 | Popped word is the final data word |
| rd_bytes | output | 2 | Valid bytes of the final word |
| rd_sts_valid | output | 1 | `rd_data` holds a status word |
| level | output | 10 | Words stored |
| full | output | 1 | 512 words stored |
| empty | output | 1 | No words stored |
| drop_count | output | 16 | Overflowed frames |

## Verification
The bench goes after the threshold edge: 15 versus 16 words. A design that compares bytes off by one would open the frame one word early or late.

It fills exactly 511 data words plus the status word. A design that forgets the reserved word would drop a frame that fits, or lose its status.

It overflows a frame twice: once with the reader still idle, where a missing rewind would leave orphan words in `level`; and once with the reader already inside the frame, where a rewind would corrupt words the reader is consuming and the status would lack its error bit.

It also holds `rd_en` high in store-and-forward mode before the status word exists, which exposes a design that leaks data early.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        TAG_DATA = 2'd0,
        TAG_LAST = 2'd1,
        TAG_STAT = 2'd2
    } tag_e;

    typedef struct packed {
        tag_e              tag;
        logic [1:0]        nbytes;
        logic [WORD_W-1:0] word;
    } entry_t;

endpackage

// File: rtl/rxsf_ram.sv
module rxsf_ram
    import rxsf_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  entry_t            wdata,
    input  logic [ADDR_W-1:0] raddr,
    output entry_t            rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rxsf_wr.sv
module rxsf_wr
    import rxsf_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int TH_W   = ADDR_W + 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic [1:0]        wr_bytes,
    input  logic              sts_valid,
    input  logic [WORD_W-1:0] sts_data,
    input  logic [ADDR_W:0]   rptr,
    input  logic              rd_in_cur,
    input  logic [TH_W-1:0]   thresh,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output entry_t            mem_wdata,
    output logic [ADDR_W:0]   wptr,
    output logic              cut_ok,
    output logic              commit,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef enum logic [1:0] {W_IDLE, W_FRAME, W_WAIT_STS, W_DISCARD} wst_e;

    wst_e             st, nxt;
    logic [PTR_W-1:0] fstart;
    logic             trunc_q;
    logic [PTR_W-1:0] used, cur;
    logic             room, inc, ovf;

    assign used = wptr - rptr;
    assign cur  = wptr - fstart;
    assign room = used < PTR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt       = st;
        mem_we    = 1'b0;
        mem_addr  = wptr[ADDR_W-1:0];
        mem_wdata = '0;
        inc       = 1'b0;
        ovf       = 1'b0;
        commit    = 1'b0;
        unique case (st)
            W_IDLE, W_FRAME: begin
                if (wr_valid) begin
                    if (!room) begin
                        ovf = 1'b1;
                        nxt = W_DISCARD;
                    end else begin
                        mem_we           = 1'b1;
                        mem_wdata.tag    = wr_last ? TAG_LAST : TAG_DATA;
                        mem_wdata.nbytes = wr_last ? wr_bytes : 2'd0;
                        mem_wdata.word   = wr_data;
                        inc              = 1'b1;
                        nxt              = wr_last ? W_WAIT_STS : W_FRAME;
                    end
                end
            end
            W_WAIT_STS: begin
                if (sts_valid) begin
                    mem_we         = 1'b1;
                    mem_wdata.tag  = TAG_STAT;
                    mem_wdata.word = sts_data;
                    inc            = 1'b1;
                    commit         = 1'b1;
                    nxt            = W_IDLE;
                end
            end
            W_DISCARD: begin
                if (sts_valid) begin
                    if (trunc_q) begin
                        mem_we         = 1'b1;
                        mem_wdata.tag  = TAG_STAT;
                        mem_wdata.word = sts_data | {1'b1, {(WORD_W-1){1'b0}}};
                        inc            = 1'b1;
                        commit         = 1'b1;
                    end
                    nxt = W_IDLE;
                end
            end
            default: nxt = W_IDLE;
        endcase
    end

    assign cut_ok = ((st == W_FRAME) || (st == W_WAIT_STS)) &&
                    ({cur, 2'b00} >= {{(PTR_W+2-TH_W){1'b0}}, thresh});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr       <= '0;
            fstart     <= '0;
            trunc_q    <= 1'b0;
            drop_count <= '0;
        end else begin
            if (ovf) begin
                trunc_q    <= rd_in_cur;
                drop_count <= drop_count + 1'b1;
            end
            if (ovf && !rd_in_cur) wptr <= fstart;
            else if (inc)          wptr <= wptr + 1'b1;
            if (commit)            fstart <= wptr + 1'b1;
        end
    end

    // R8: an overflow the reader has not reached removes the whole frame
    a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !rd_in_cur) |=> (wptr == $past(fstart)));

    // R9: a truncated frame still gets its status word stored
    a_r9_trunc_status: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_DISCARD && trunc_q && sts_valid) |=> (wptr == $past(wptr) + 1'b1));

endmodule

// File: rtl/rxsf_rd.sv
module rxsf_rd
    import rxsf_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wptr,
    input  logic              frames_avail,
    input  logic              cut_ok,
    input  logic              store_fwd,
    input  entry_t            head,
    output logic [ADDR_W:0]   rptr,
    output logic              rd_avail,
    output logic              in_frame,
    output logic              pop_sts,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last,
    output logic [1:0]        rd_bytes,
    output logic              rd_sts_valid
);
    typedef enum logic {R_IDLE, R_FRAME} rst_e;

    rst_e st, nxt;
    logic pop;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= R_IDLE;
        else        st <= nxt;
    end

    assign rd_avail = (st == R_FRAME) && (wptr != rptr);
    assign in_frame = (st == R_FRAME);

    always_comb begin
        nxt     = st;
        pop     = 1'b0;
        pop_sts = 1'b0;
        unique case (st)
            R_IDLE: begin
                if (frames_avail || (!store_fwd && cut_ok)) nxt = R_FRAME;
            end
            R_FRAME: begin
                if (rd_en && rd_avail) begin
                    pop = 1'b1;
                    if (head.tag == TAG_STAT) begin
                        pop_sts = 1'b1;
                        nxt     = R_IDLE;
                    end
                end
            end
            default: nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr         <= '0;
            rd_valid     <= 1'b0;
            rd_sts_valid <= 1'b0;
            rd_last      <= 1'b0;
            rd_bytes     <= '0;
            rd_data      <= '0;
        end else begin
            rd_valid     <= pop && (head.tag != TAG_STAT);
            rd_sts_valid <= pop && (head.tag == TAG_STAT);
            rd_last      <= pop && (head.tag == TAG_LAST);
            rd_bytes     <= (pop && head.tag == TAG_LAST) ? head.nbytes : 2'd0;
            if (pop) begin
                rd_data <= head.word;
                rptr    <= rptr + 1'b1;
            end
        end
    end

    // R2: store-and-forward keeps the reader out until a frame is complete
    a_r2_sf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == R_IDLE && store_fwd && !frames_avail) |=> (st == R_IDLE));

    // R2: a popped word is either data or status, never both
    a_r2_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_sts_valid));

    // R10: no output word without a request
    a_r10_no_req_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && !rd_sts_valid));

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
    import rxsf_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int TH_W      = ADDR_W + 3,
    parameter int CNT_W     = 16,
    parameter int TH_RESET  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TH_W-1:0]   cfg_thresh,
    input  logic              cfg_store_fwd,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              wr_last,
    input  logic [1:0]        wr_bytes,
    input  logic              sts_valid,
    input  logic [31:0]       sts_data,
    input  logic              rd_en,
    output logic              rd_avail,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              rd_last,
    output logic [1:0]        rd_bytes,
    output logic              rd_sts_valid,
    output logic [ADDR_W:0]   level,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [TH_W-1:0]  thresh_q;
    logic             sf_q;
    logic [PTR_W-1:0] wptr, rptr, frames_q;
    logic             mem_we, cut_ok, commit, pop_sts, in_frame, rd_in_cur;
    logic [ADDR_W-1:0] mem_addr;
    entry_t           mem_wdata, head;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q <= TH_W'(TH_RESET);
            sf_q     <= 1'b0;
        end else if (cfg_we) begin
            thresh_q <= cfg_thresh;
            sf_q     <= cfg_store_fwd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frames_q <= '0;
        else        frames_q <= frames_q + {{(PTR_W-1){1'b0}}, commit}
                                         - {{(PTR_W-1){1'b0}}, pop_sts};
    end

    assign rd_in_cur = (frames_q == '0) && in_frame;

    rxsf_wr #(.ADDR_W(ADDR_W), .TH_W(TH_W), .CNT_W(CNT_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_bytes(wr_bytes),
        .sts_valid(sts_valid), .sts_data(sts_data),
        .rptr(rptr), .rd_in_cur(rd_in_cur), .thresh(thresh_q),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wptr(wptr), .cut_ok(cut_ok), .commit(commit), .drop_count(drop_count)
    );

    rxsf_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rptr[ADDR_W-1:0]), .rdata(head)
    );

    rxsf_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .wptr(wptr), .frames_avail(frames_q != '0), .cut_ok(cut_ok),
        .store_fwd(sf_q), .head(head),
        .rptr(rptr), .rd_avail(rd_avail), .in_frame(in_frame), .pop_sts(pop_sts),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_bytes(rd_bytes), .rd_sts_valid(rd_sts_valid)
    );

    assign level = wptr - rptr;
    assign full  = (wptr[ADDR_W] != rptr[ADDR_W]) &&
                   (wptr[ADDR_W-1:0] == rptr[ADDR_W-1:0]);
    assign empty = (wptr == rptr);

    // R7: occupancy never exceeds capacity
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PTR_W'(DEPTH));

    // R7: full and empty are exclusive
    a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R6: every status popped belongs to a queued frame
    a_r6_sts_counted: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sts_valid |-> ($past(frames_q) != '0));

endmodule

// File: tb/rx_status_fifo_test.sv
module rx_status_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_thresh = '0;
    logic        cfg_store_fwd = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_last = 1'b0;
    logic [1:0]  wr_bytes = '0;
    logic        sts_valid = 1'b0;
    logic [31:0] sts_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_avail, rd_valid, rd_last, rd_sts_valid, full, empty;
    logic [31:0] rd_data;
    logic [1:0]  rd_bytes;
    logic [9:0]  level;
    logic [15:0] drop_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rx_status_fifo uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_thresh(cfg_thresh), .cfg_store_fwd(cfg_store_fwd),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_bytes(wr_bytes),
        .sts_valid(sts_valid), .sts_data(sts_data), .rd_en(rd_en),
        .rd_avail(rd_avail), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .rd_bytes(rd_bytes), .rd_sts_valid(rd_sts_valid),
        .level(level), .full(full), .empty(empty), .drop_count(drop_count)
    );

    function automatic logic [31:0] pat(input logic [7:0] id, input int i);
        logic [31:0] v = i;
        return {id, v[23:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [11:0] th, input logic sf);
        cfg_we = 1'b1; cfg_thresh = th; cfg_store_fwd = sf;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] d, input logic last, input logic [1:0] nb);
        wr_valid = 1'b1; wr_data = d; wr_last = last; wr_bytes = nb;
        tick();
        wr_valid = 1'b0; wr_last = 1'b0; wr_bytes = '0;
    endtask

    task automatic put_status(input logic [31:0] s);
        sts_valid = 1'b1; sts_data = s;
        tick();
        sts_valid = 1'b0;
    endtask

    task automatic put_frame(input logic [7:0] id, input int n, input logic [1:0] nb,
                             input logic [31:0] s);
        for (int i = 0; i < n; i++) put_word(pat(id, i), i == n - 1, nb);
        put_status(s);
    endtask

    task automatic drain(input logic [7:0] id, input int n, input bit has_last,
                         input logic [1:0] nb, input logic [31:0] s, input string req);
        int got = 0;
        int bad = 0;
        int guard = 0;
        bit seen = 1'b0;
        logic [31:0] sv = '0;
        rd_en = 1'b1;
        while (!seen && guard < 2000) begin
            tick();
            guard++;
            if (rd_valid) begin
                if (rd_data != pat(id, got)) bad++;
                if (has_last && got == n - 1) begin
                    if (!rd_last || rd_bytes != nb) bad++;
                end else if (rd_last) bad++;
                got++;
            end
            if (rd_sts_valid) begin
                seen = 1'b1;
                sv   = rd_data;
            end
        end
        rd_en = 1'b0;
        check(bad == 0, {req, " data order and tags"}, bad, 0);
        check(got == n, {req, " data word count"}, got, n);
        check(seen && sv == s, {req, " status word"}, sv, s);
    endtask

    task automatic t_reset();
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(full == 1'b0, "R1 full", full, 0);
        check(level == 0, "R1 level", level, 0);
        check(rd_avail == 1'b0, "R1 rd_avail", rd_avail, 0);
        check(drop_count == 0, "R1 drop_count", drop_count, 0);
    endtask

    task automatic t_default_thresh();
        for (int i = 0; i < 15; i++) put_word(pat(8'h11, i), 1'b0, 2'd0);
        tick(); tick(); tick();
        check(rd_avail == 1'b0, "R3 below 64 bytes", rd_avail, 0);
        put_word(pat(8'h11, 15), 1'b0, 2'd0);
        tick();
        check(rd_avail == 1'b1, "R3 at 64 bytes", rd_avail, 1);
        put_word(pat(8'h11, 16), 1'b1, 2'd2);
        put_status(32'h0000_1111);
        drain(8'h11, 17, 1'b1, 2'd2, 32'h0000_1111, "R3 R11");
    endtask

    task automatic t_short_cut();
        for (int i = 0; i < 4; i++) put_word(pat(8'h12, i), i == 3, 2'd1);
        tick(); tick();
        check(rd_avail == 1'b0, "R5 short frame held", rd_avail, 0);
        put_status(32'h0000_2222);
        tick();
        check(rd_avail == 1'b1, "R5 short frame open", rd_avail, 1);
        drain(8'h12, 4, 1'b1, 2'd1, 32'h0000_2222, "R5");
    endtask

    task automatic t_prog_thresh();
        set_cfg(12'd16, 1'b0);
        for (int i = 0; i < 3; i++) put_word(pat(8'h13, i), 1'b0, 2'd0);
        tick(); tick();
        check(rd_avail == 1'b0, "R4 below 16 bytes", rd_avail, 0);
        put_word(pat(8'h13, 3), 1'b0, 2'd0);
        tick();
        check(rd_avail == 1'b1, "R4 at 16 bytes", rd_avail, 1);
        put_word(pat(8'h13, 4), 1'b1, 2'd0);
        put_status(32'h0000_3333);
        drain(8'h13, 5, 1'b1, 2'd0, 32'h0000_3333, "R4");
    endtask

    task automatic t_store_fwd();
        bit leak = 1'b0;
        set_cfg(12'd64, 1'b1);
        for (int i = 0; i < 20; i++) put_word(pat(8'h14, i), i == 19, 2'd3);
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (rd_valid || rd_sts_valid) leak = 1'b1;
        end
        rd_en = 1'b0;
        check(rd_avail == 1'b0, "R2 held before status", rd_avail, 0);
        check(leak == 1'b0, "R10 rd_en ignored", leak, 0);
        check(level == 20, "R10 nothing consumed", level, 20);
        put_status(32'h0000_4444);
        tick();
        check(rd_avail == 1'b1, "R2 open after status", rd_avail, 1);
        drain(8'h14, 20, 1'b1, 2'd3, 32'h0000_4444, "R2");
    endtask

    task automatic t_multi();
        put_frame(8'h21, 1, 2'd1, 32'h0000_5501);
        put_frame(8'h22, 5, 2'd3, 32'h0000_5502);
        put_frame(8'h23, 3, 2'd0, 32'h0000_5503);
        check(level == 12, "R6 R7 level with three frames", level, 12);
        drain(8'h21, 1, 1'b1, 2'd1, 32'h0000_5501, "R6 frame A");
        drain(8'h22, 5, 1'b1, 2'd3, 32'h0000_5502, "R6 frame B");
        drain(8'h23, 3, 1'b1, 2'd0, 32'h0000_5503, "R6 frame C");
        check(empty == 1'b1, "R6 empty after drain", empty, 1);
    endtask

    task automatic t_full();
        put_frame(8'h31, 511, 2'd0, 32'h0000_6600);
        check(full == 1'b1, "R7 full at 512", full, 1);
        check(level == 512, "R7 level at 512", level, 512);
        check(drop_count == 0, "R7 exact fit not dropped", drop_count, 0);
        drain(8'h31, 511, 1'b1, 2'd0, 32'h0000_6600, "R7");
        check(empty == 1'b1 && level == 0, "R7 empty after drain", level, 0);
    endtask

    task automatic t_drop();
        put_frame(8'h41, 520, 2'd0, 32'h0000_DEAD);
        check(drop_count == 1, "R8 drop counted", drop_count, 1);
        check(level == 0, "R8 level restored", level, 0);
        tick();
        check(rd_avail == 1'b0, "R8 nothing readable", rd_avail, 0);
        put_frame(8'h42, 3, 2'd2, 32'h0000_7700);
        drain(8'h42, 3, 1'b1, 2'd2, 32'h0000_7700, "R8 next frame");
    endtask

    task automatic t_trunc();
        set_cfg(12'd64, 1'b0);
        put_frame(8'h51, 520, 2'd0, 32'h0000_0ABC);
        check(drop_count == 2, "R9 drop counted", drop_count, 2);
        check(full == 1'b1, "R9 status fits reserve", full, 1);
        drain(8'h51, 511, 1'b0, 2'd0, 32'h8000_0ABC, "R9");
        check(empty == 1'b1, "R9 empty after drain", empty, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_default_thresh();
        t_short_cut();
        t_prog_thresh();
        t_store_fwd();
        t_multi();
        t_full();
        t_drop();
        t_trunc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule